// File: doc/BRIEF.md
# Legacy Memory Region Target Decoder

This block sits on the request path of a memory controller hub. It decides whether a memory request goes to main DRAM or to the downstream I/O port. The address range from 768 KB to 1 MB is split into thirteen shadow segments. Each segment has its own read-enable and write-enable bit. An access that its segment does not allow falls through to the I/O port.

Above 1 MB, requests below a programmable top-of-low-memory limit go to DRAM. Up to three enabled carve-out windows punch holes in that range: a system-management area, a legacy ISA hole and graphics stolen memory. Everything else goes to the I/O port. A request carrying the write-back attribute that decodes to the I/O port cannot be serviced there. It is flagged on the response and latches a sticky error flag.

Requests arrive on a valid/ready stream, and decisions leave on a valid/ready stream through a single output register. `req_ready` is high whenever the output register is empty or is being drained in the same cycle (`!rsp_valid || rsp_ready`). While `rsp_ready` is low, a pending decision is held unchanged and no new request is accepted. The decode does not depend on whether the processor or the I/O port originated the request. Configuration is written through a plain register-write port.

Top module: `legacy_mem_decoder`

## Requirements
- R1: After reset, `rsp_valid` and `err_flag` are 0, all segment enables and window enables are 0, and the top-of-low-memory register is 0, so every request decodes to the I/O port.
- R2: Segment layout: segment i (i = 0..11) covers 0xC0000 + i*0x4000 to 0xC0000 + i*0x4000 + 0x3FFF, and segment 12 covers 0xF0000 to 0xFFFFF. Its controls are in configuration offset 0: bit 2i is the read enable and bit 2i+1 is the write enable.
- R3: A read to a legacy segment goes to DRAM (`rsp_to_io`=0) if its read enable is set, and otherwise to the I/O port (`rsp_to_io`=1). A write follows the write enable of its segment in the same way.
- R4: Addresses below 0xC0000 always go to the I/O port.
- R5: Addresses from 0x100000 up to but not including the top-of-low-memory value (offset 1) go to DRAM unless they fall in an enabled window. Addresses at or above that value go to the I/O port.
- R6: Window k (k = 0..2) has its base at offset 2+2k and its size at offset 3+2k, and its enable is bit k of offset 8. An address in [base, base+size) inside the DRAM range goes to the I/O port when the window is enabled. A disabled window has no effect on the decode.
- R7: An accepted request with `req_wb`=1 that decodes to the I/O port gives `rsp_err`=1 and sets `err_flag`. A write-back request that decodes to DRAM gives `rsp_err`=0 and leaves `err_flag` unchanged.
- R8: `err_flag` stays set until a configuration write to offset 9 with data bit 0 = 1. Writing 0 to that bit has no effect. A new error in the same cycle as a clear keeps the flag set.
- R9: A request accepted at a clock edge produces `rsp_valid`=1 with its decision after that edge. `req_ready` = `!rsp_valid || rsp_ready`. While `rsp_valid`=1 and `rsp_ready`=0, the response stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wb | input | 1 | Request carries the write-back attribute |
| rsp_valid | output | 1 | Decision valid |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_to_io | output | 1 | 1 = I/O port, 0 = DRAM |
| rsp_err | output | 1 | Write-back routed to the I/O port |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| err_flag | output | 1 | Sticky write-back error flag |

## Verification
On every cycle, the assertions check the stream rules:
- an accepted request yields a valid response next cycle;
- a stalled response holds its value;
- a flagged response always targets the I/O port;
- the error flag rises only with a flagged response and stays set until cleared;
- at most one segment matches an address.

Only the bench scenarios can show that the decision itself is right. They sweep the first and last byte of every segment under mixed read/write enables, probe each window edge with windows on and off, and cross the 1 MB and top-of-memory limits. They also cover a clear that coincides with a new error, and decisions held under back-pressure.

// File: rtl/lmd_pkg.sv
package lmd_pkg;
  localparam int unsigned SEG_NUM      = 13;
  localparam int unsigned SEG_SMALL    = 12;
  localparam longint unsigned LEG_BASE = 64'h000C0000;
  localparam longint unsigned SEG_STEP = 64'h00004000;
  localparam longint unsigned TOP_BASE = 64'h000F0000;
  localparam longint unsigned LEG_END  = 64'h000FFFFF;
  localparam longint unsigned HIGH_MEM = 64'h00100000;

  typedef enum logic {
    TGT_DRAM = 1'b0,
    TGT_IO   = 1'b1
  } tgt_e;

  function automatic longint unsigned seg_lo(int unsigned i);
    return (i < SEG_SMALL) ? LEG_BASE + i * SEG_STEP : TOP_BASE;
  endfunction

  function automatic longint unsigned seg_hi(int unsigned i);
    return (i < SEG_SMALL) ? LEG_BASE + (i + 1) * SEG_STEP - 1 : LEG_END;
  endfunction
endpackage

// File: rtl/lmd_cfg_regs.sv
module lmd_cfg_regs #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NUM_WIN = 3,
  parameter int unsigned SEG_NUM = 13,
  parameter int unsigned CFG_AW  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [CFG_AW-1:0]               cfg_addr,
  input  logic [ADDR_W-1:0]               cfg_wdata,
  output logic [SEG_NUM-1:0]              seg_re,
  output logic [SEG_NUM-1:0]              seg_we,
  output logic [ADDR_W-1:0]               tolm,
  output logic [NUM_WIN-1:0]              win_en,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  win_base,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  win_size,
  output logic                            err_clr
);
  localparam int unsigned OFS_SEG = 0;
  localparam int unsigned OFS_TOP = 1;
  localparam int unsigned OFS_WIN = 2;
  localparam int unsigned OFS_EN  = OFS_WIN + 2 * NUM_WIN;
  localparam int unsigned OFS_CLR = OFS_EN + 1;

  logic [2*SEG_NUM-1:0] seg_ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_ctl <= '0;
      tolm    <= '0;
      win_en  <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(OFS_SEG)) seg_ctl <= cfg_wdata[2*SEG_NUM-1:0];
      if (cfg_addr == CFG_AW'(OFS_TOP)) tolm    <= cfg_wdata;
      if (cfg_addr == CFG_AW'(OFS_EN))  win_en  <= cfg_wdata[NUM_WIN-1:0];
    end
  end

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_base[k] <= '0;
        win_size[k] <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == CFG_AW'(OFS_WIN + 2*k))     win_base[k] <= cfg_wdata;
        if (cfg_addr == CFG_AW'(OFS_WIN + 2*k + 1)) win_size[k] <= cfg_wdata;
      end
    end
  end

  for (genvar i = 0; i < SEG_NUM; i++) begin : g_seg
    assign seg_re[i] = seg_ctl[2*i];
    assign seg_we[i] = seg_ctl[2*i+1];
  end

  assign err_clr = cfg_we && (cfg_addr == CFG_AW'(OFS_CLR)) && cfg_wdata[0];
endmodule

// File: rtl/lmd_seg_decode.sv
module lmd_seg_decode #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SEG_NUM = 13
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               is_write,
  input  logic [SEG_NUM-1:0] seg_re,
  input  logic [SEG_NUM-1:0] seg_we,
  output logic               in_legacy,
  output logic               allow
);
  import lmd_pkg::*;

  logic [SEG_NUM-1:0] hit;

  for (genvar i = 0; i < SEG_NUM; i++) begin : g_hit
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(seg_lo(i));
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(seg_hi(i));
    assign hit[i] = (addr >= LO) && (addr <= HI);
  end

  always_comb begin
    in_legacy = |hit;
    allow     = |(hit & (is_write ? seg_we : seg_re));
    // R2: segments never overlap
    assert_seg_onehot_R2: assert ($onehot0(hit));
  end
endmodule

// File: rtl/lmd_window_match.sv
module lmd_window_match #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] size,
  output logic              hit
);
  logic [ADDR_W:0] lim;

  assign lim = {1'b0, base} + {1'b0, size};
  assign hit = en && (addr >= base) && ({1'b0, addr} < lim);
endmodule

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NUM_WIN = 3,
  parameter int unsigned CFG_AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_wb,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_to_io,
  output logic              rsp_err,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              err_flag
);
  import lmd_pkg::*;

  localparam logic [ADDR_W-1:0] ONE_MB = ADDR_W'(HIGH_MEM);

  logic [SEG_NUM-1:0]             seg_re, seg_we;
  logic [ADDR_W-1:0]              tolm;
  logic [NUM_WIN-1:0]             win_en, win_hit;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_base, win_size;
  logic                           err_clr;
  logic                           in_legacy, seg_allow, in_main, to_dram, accept;
  tgt_e                           tgt;

  lmd_cfg_regs #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .SEG_NUM(SEG_NUM), .CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .seg_re(seg_re), .seg_we(seg_we), .tolm(tolm), .win_en(win_en),
    .win_base(win_base), .win_size(win_size), .err_clr(err_clr)
  );

  lmd_seg_decode #(.ADDR_W(ADDR_W), .SEG_NUM(SEG_NUM)) u_seg (
    .addr(req_addr), .is_write(req_write), .seg_re(seg_re), .seg_we(seg_we),
    .in_legacy(in_legacy), .allow(seg_allow)
  );

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    lmd_window_match #(.ADDR_W(ADDR_W)) u_win (
      .addr(req_addr), .en(win_en[k]), .base(win_base[k]), .size(win_size[k]),
      .hit(win_hit[k])
    );
  end

  assign in_main   = (req_addr >= ONE_MB) && (req_addr < tolm);
  assign to_dram   = (in_legacy && seg_allow) || (in_main && !(|win_hit));
  assign tgt       = to_dram ? TGT_DRAM : TGT_IO;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_to_io <= 1'b0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_to_io <= (tgt == TGT_IO);
      rsp_err   <= req_wb && (tgt == TGT_IO);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                err_flag <= 1'b0;
    else if (accept && req_wb && tgt == TGT_IO) err_flag <= 1'b1;
    else if (err_clr)                          err_flag <= 1'b0;
  end

  assert_accept_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_to_io) && $stable(rsp_err));
  assert_err_targets_io_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_to_io);
  assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> rsp_valid && rsp_err);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);
endmodule

// File: tb/sim_legacy_mem_decoder.sv
module sim_legacy_mem_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0, req_wb = 0, rsp_ready = 1;
  logic [31:0] req_addr = 0, cfg_wdata = 0;
  logic [3:0]  cfg_addr = 0;
  logic        cfg_we = 0;
  logic        req_ready, rsp_valid, rsp_to_io, rsp_err, err_flag;

  int total = 0, bad = 0;
  bit done = 0;

  legacy_mem_decoder u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wb(req_wb),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_to_io(rsp_to_io),
    .rsp_err(rsp_err), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .err_flag(err_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit [25:0] m_seg;
  longint    m_tolm;
  longint    m_wb[3];
  longint    m_ws[3];
  bit [2:0]  m_wen;
  bit        m_valid, m_io, m_err, m_flag;
  string     m_tag = "R3";

  function automatic bit ref_io(longint a, bit w, output string tag);
    int s;
    if (a >= 'hC0000 && a <= 'hFFFFF) begin
      s = (a < 'hF0000) ? int'((a - 'hC0000) / 'h4000) : 12;
      tag = "R3";
      return !(w ? m_seg[2*s+1] : m_seg[2*s]);
    end
    if (a < 'hC0000) begin tag = "R4"; return 1; end
    if (a < m_tolm) begin
      for (int k = 0; k < 3; k++)
        if (m_wen[k] && a >= m_wb[k] && a < m_wb[k] + m_ws[k]) begin tag = "R6"; return 1; end
      tag = "R5";
      return 0;
    end
    tag = "R5";
    return 1;
  endfunction

  always @(posedge clk) begin
    bit acc, io;
    string tg;
    if (!rst_n) begin
      m_seg = 0; m_tolm = 0; m_wen = 0; m_valid = 0; m_io = 0; m_err = 0; m_flag = 0;
      for (int k = 0; k < 3; k++) begin m_wb[k] = 0; m_ws[k] = 0; end
    end else begin
      acc = req_valid && (!m_valid || rsp_ready);
      io  = ref_io(longint'(req_addr), req_write, tg);
      if (acc) begin
        m_valid = 1; m_io = io; m_err = req_wb && io; m_tag = tg;
      end else if (rsp_ready) m_valid = 0;
      if (acc && req_wb && io) m_flag = 1;
      else if (cfg_we && cfg_addr == 9 && cfg_wdata[0]) m_flag = 0;
      if (cfg_we) begin
        case (cfg_addr)
          0: m_seg = cfg_wdata[25:0];
          1: m_tolm = longint'(cfg_wdata);
          8: m_wen = cfg_wdata[2:0];
          default: begin
            for (int k = 0; k < 3; k++) begin
              if (cfg_addr == 4'(2+2*k)) m_wb[k] = longint'(cfg_wdata);
              if (cfg_addr == 4'(3+2*k)) m_ws[k] = longint'(cfg_wdata);
            end
          end
        endcase
      end
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // compared against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rsp_valid == m_valid, "R9", rsp_valid, m_valid);
      chk(req_ready == (!m_valid || rsp_ready), "R9", req_ready, !m_valid || rsp_ready);
      if (m_valid) begin
        chk(rsp_to_io == m_io, m_tag, rsp_to_io, m_io);
        chk(rsp_err == m_err, "R7", rsp_err, m_err);
      end
      chk(err_flag == m_flag, "R8", err_flag, m_flag);
    end
  end

  task automatic cfg(int a, logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic send(logic [31:0] a, bit w, bit wb);
    @(posedge clk); #1;
    req_valid = 1; req_addr = a; req_write = w; req_wb = wb;
    @(posedge clk); #1;
    req_valid = 0; req_wb = 0;
  endtask

  task automatic summary;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R1", rsp_valid, 0);
    chk(err_flag == 0, "R1", err_flag, 0);
    send(32'h000C0000, 0, 0);
    @(negedge clk); chk(rsp_to_io == 1, "R1", rsp_to_io, 1);
    send(32'h00100000, 1, 0);
    @(negedge clk); chk(rsp_to_io == 1, "R1", rsp_to_io, 1);

    // R2 R3: mixed enables, every segment edge, read and write
    cfg(0, 32'h02C91B6E);
    for (int i = 0; i < 13; i++) begin
      logic [31:0] lo, hi;
      lo = (i < 12) ? 32'hC0000 + i * 32'h4000 : 32'hF0000;
      hi = (i < 12) ? lo + 32'h3FFF : 32'hFFFFF;
      send(lo, 0, 0); send(lo, 1, 0); send(hi, 0, 0); send(hi, 1, 0);
    end
    cfg(0, 32'h03FFFFFF);
    send(32'h000D7FFF, 0, 0); send(32'h000F8000, 1, 0);

    // R4 and R5
    send(32'h00000000, 0, 0); send(32'h000A0000, 1, 0); send(32'h000BFFFF, 0, 0);
    cfg(1, 32'h08000000);
    send(32'h00100000, 0, 0); send(32'h07FFFFFF, 1, 0);
    send(32'h08000000, 0, 0); send(32'hFFFFFFFF, 0, 0);

    // R6: windows
    cfg(2, 32'h00200000); cfg(3, 32'h00010000);
    cfg(4, 32'h00300000); cfg(5, 32'h00001000);
    cfg(6, 32'h07FF0000); cfg(7, 32'h00010000);
    cfg(8, 32'h5);
    send(32'h001FFFFF, 0, 0); send(32'h00200000, 0, 0);
    send(32'h0020FFFF, 1, 0); send(32'h00210000, 0, 0);
    send(32'h00300000, 0, 0); send(32'h07FF0000, 0, 0); send(32'h07FFFFFF, 1, 0);
    cfg(8, 32'h2);
    send(32'h00200000, 0, 0); send(32'h00300000, 0, 0); send(32'h00300FFF, 1, 0);
    send(32'h00301000, 0, 0);

    // R7 R8: write-back errors and clearing
    send(32'h00100000, 1, 1);
    @(negedge clk); chk(err_flag == 0, "R7", err_flag, 0);
    send(32'h000A0000, 1, 1);
    @(negedge clk); chk(err_flag == 1, "R7", err_flag, 1);
    cfg(9, 32'h0);
    @(negedge clk); chk(err_flag == 1, "R8", err_flag, 1);
    cfg(9, 32'h1);
    @(negedge clk); chk(err_flag == 0, "R8", err_flag, 0);
    @(posedge clk); #1;
    cfg_we = 1; cfg_addr = 9; cfg_wdata = 1;
    req_valid = 1; req_addr = 32'h08000000; req_write = 1; req_wb = 1;
    @(posedge clk); #1;
    cfg_we = 0; req_valid = 0; req_wb = 0;
    @(negedge clk); chk(err_flag == 1, "R8", err_flag, 1);
    cfg(9, 32'h1);

    // R9: back-pressure with a stream of requests
    for (int i = 0; i < 24; i++) begin
      @(posedge clk); #1;
      rsp_ready = (i % 3) != 0;
      req_valid = (i % 5) != 4;
      req_addr  = (i % 2) ? 32'h000C0000 + i * 32'h2000 : 32'h00100000 + i * 32'h100000;
      req_write = i[0];
      req_wb    = (i % 4) == 1;
    end
    @(posedge clk); #1;
    req_valid = 0; req_wb = 0; rsp_ready = 1;
    repeat (3) @(posedge clk);
    #1 summary();
  end
endmodule